// File: doc/BRIEF.md
# Busy-Status Read Multiplexer

This block sits on the read path of a sector-programmed non-volatile memory. While no internal program or erase cycle is in progress, every read returns the word fetched from the storage array unchanged. While the internal timer is running, the same read returns progress status instead. One status bit is a polarity flag: it carries the inverse of the matching bit of the most recently loaded byte during a program cycle, and it carries 0 during a whole-array clear, because an erased cell reads 1. A second status bit is a toggle that takes the opposite value on each read made while busy. Software can poll either bit. When the flag matches the loaded data, or when the toggle stops changing, the cycle has finished.

The result is registered on the read strobe and is held on `rd_data` until the next strobe. The toggle state changes only on a strobe that lands inside a busy period. Idle reads and idle cycles leave it unchanged. Parameters set the word width and the positions of the two status bits. A further parameter sets whether the remaining bits carry array data or zero while busy.

Top module: `poll_status_read`

## Requirements
- R1: After reset `rd_data` is 0 and the toggle state is 0.
- R2: A read strobe with `busy` low loads `rd_data` with `array_data` on the same clock edge.
- R3: A read strobe with `busy` high and `erase` low loads bit POLL_BIT (default 7) of `rd_data` with the inverse of bit POLL_BIT of `last_byte`.
- R4: A read strobe with `busy` high and `erase` high loads bit POLL_BIT of `rd_data` with 0, whatever `last_byte` holds.
- R5: On a read strobe with `busy` high, bit TOGGLE_BIT (default 6) of `rd_data` takes the toggle state, which then inverts. The first busy read after reset therefore returns 0, and the next returns 1.
- R6: The toggle state changes only on busy reads. Idle reads and cycles without a strobe leave it unchanged, so alternation continues across gaps, across idle reads and into the next busy period.
- R7: `rd_data` stays unchanged on every cycle without a read strobe, even if the other inputs change.
- R8: With ZERO_FILL = 0 (the default), the bits other than POLL_BIT and TOGGLE_BIT carry `array_data` during a busy read. With ZERO_FILL = 1 they carry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | One-cycle read request |
| busy | input | 1 | Internal program or erase cycle in progress |
| erase | input | 1 | Running cycle is a whole-array clear (valid while busy) |
| last_byte | input | DATA_W | Most recently loaded data byte |
| array_data | input | DATA_W | Word read from the storage array |
| rd_data | output | DATA_W | Registered read result |

## Verification
The assertions assume that `busy`, `erase`, `last_byte` and `array_data` are steady at the clock edge that samples a strobe. They also assume that `erase` matters only while `busy` is high. The toggle checks further assume that no reset occurs between two busy reads. The bench drives every input at the falling edge and holds it through the next rising edge. It raises `rd_stb` for exactly one cycle per read. Between reads it changes `last_byte` and `array_data` freely, which exercises the hold behaviour without breaking those assumptions.

// File: rtl/poll_rd_pkg.sv
package poll_rd_pkg;
   typedef enum logic [1:0] {
      SRC_ARRAY = 2'd0,
      SRC_PROG  = 2'd1,
      SRC_ERASE = 2'd2
   } rd_src_e;
endpackage

// File: rtl/poll_toggle_cell.sv
module poll_toggle_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic advance,
   output logic tgl_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tgl_q <= 1'b0;
      else if (advance) tgl_q <= ~tgl_q;
   end
endmodule

// File: rtl/poll_status_mux.sv
module poll_status_mux
   import poll_rd_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int POLL_BIT   = 7,
   parameter int TOGGLE_BIT = 6,
   parameter bit ZERO_FILL  = 1'b0
) (
   input  rd_src_e           src,
   input  logic [DATA_W-1:0] last_byte,
   input  logic [DATA_W-1:0] array_data,
   input  logic              tgl,
   output logic [DATA_W-1:0] word
);
   logic is_busy;
   logic poll_val;

   always_comb begin
      is_busy  = (src != SRC_ARRAY);
      poll_val = (src == SRC_ERASE) ? 1'b0 : ~last_byte[POLL_BIT];
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (b == POLL_BIT) begin : g_poll
         assign word[b] = is_busy ? poll_val : array_data[b];
      end else if (b == TOGGLE_BIT) begin : g_tgl
         assign word[b] = is_busy ? tgl : array_data[b];
      end else if (ZERO_FILL) begin : g_zero
         assign word[b] = is_busy ? 1'b0 : array_data[b];
      end else begin : g_pass
         assign word[b] = array_data[b];
      end
   end
endmodule

// File: rtl/poll_out_reg.sv
module poll_out_reg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end
endmodule

// File: rtl/poll_status_read.sv
module poll_status_read
   import poll_rd_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int POLL_BIT   = 7,
   parameter int TOGGLE_BIT = 6,
   parameter bit ZERO_FILL  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_stb,
   input  logic              busy,
   input  logic              erase,
   input  logic [DATA_W-1:0] last_byte,
   input  logic [DATA_W-1:0] array_data,
   output logic [DATA_W-1:0] rd_data
);
   localparam int MIN_W = ((POLL_BIT > TOGGLE_BIT) ? POLL_BIT : TOGGLE_BIT) + 1;

   if (DATA_W < MIN_W) begin : g_bad_width
      $error("poll_status_read: DATA_W too small for status bit positions");
   end
   if (POLL_BIT == TOGGLE_BIT) begin : g_bad_pos
      $error("poll_status_read: status bits must occupy distinct positions");
   end
   if (POLL_BIT < 0 || TOGGLE_BIT < 0) begin : g_bad_neg
      $error("poll_status_read: status bit positions must be non-negative");
   end

   rd_src_e           src;
   logic              tgl;
   logic [DATA_W-1:0] word;

   always_comb begin
      if (!busy)     src = SRC_ARRAY;
      else if (erase) src = SRC_ERASE;
      else           src = SRC_PROG;
   end

   poll_toggle_cell u_tgl (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (rd_stb & busy),
      .tgl_q   (tgl)
   );

   poll_status_mux #(
      .DATA_W     (DATA_W),
      .POLL_BIT   (POLL_BIT),
      .TOGGLE_BIT (TOGGLE_BIT),
      .ZERO_FILL  (ZERO_FILL)
   ) u_mux (
      .src        (src),
      .last_byte  (last_byte),
      .array_data (array_data),
      .tgl        (tgl),
      .word       (word)
   );

   poll_out_reg #(.DATA_W(DATA_W)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (rd_stb),
      .d     (word),
      .q     (rd_data)
   );
endmodule

// File: rtl/poll_status_read_chk.sv
module poll_status_read_chk #(
   parameter int DATA_W     = 8,
   parameter int POLL_BIT   = 7,
   parameter int TOGGLE_BIT = 6,
   parameter bit ZERO_FILL  = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_stb,
   input logic              busy,
   input logic              erase,
   input logic [DATA_W-1:0] last_byte,
   input logic [DATA_W-1:0] array_data,
   input logic [DATA_W-1:0] rd_data
);
   logic busy_rd_d;
   logic have_prev;
   logic prev_t;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_rd_d <= 1'b0;
         have_prev <= 1'b0;
         prev_t    <= 1'b0;
      end else begin
         busy_rd_d <= rd_stb & busy;
         if (busy_rd_d) begin
            have_prev <= 1'b1;
            prev_t    <= rd_data[TOGGLE_BIT];
         end
      end
   end

   p_idle_true_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb && !busy |=> rd_data == $past(array_data));

   p_poll_inv_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb && busy && !erase |=> rd_data[POLL_BIT] == !$past(last_byte[POLL_BIT]));

   p_erase_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb && busy && erase |=> rd_data[POLL_BIT] == 1'b0);

   p_first_tgl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy_rd_d && !have_prev |-> rd_data[TOGGLE_BIT] == 1'b0);

   p_alternate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_rd_d && have_prev |-> rd_data[TOGGLE_BIT] != prev_t);

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> $stable(rd_data));

   for (genvar b = 0; b < DATA_W; b++) begin : g_fill
      if (b != POLL_BIT && b != TOGGLE_BIT) begin : g_chk
         p_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
            rd_stb && busy |=> rd_data[b] == (ZERO_FILL ? 1'b0 : $past(array_data[b])));
      end
   end
endmodule

bind poll_status_read poll_status_read_chk #(
   .DATA_W     (DATA_W),
   .POLL_BIT   (POLL_BIT),
   .TOGGLE_BIT (TOGGLE_BIT),
   .ZERO_FILL  (ZERO_FILL)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_stb     (rd_stb),
   .busy       (busy),
   .erase      (erase),
   .last_byte  (last_byte),
   .array_data (array_data),
   .rd_data    (rd_data)
);

// File: tb/sim_poll_status_read.sv
`timescale 1ns/1ps
module sim_poll_status_read;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rd_stb = 1'b0;
   logic       busy = 1'b0;
   logic       erase = 1'b0;
   logic [7:0] last_byte = 8'h00;
   logic [7:0] array_data = 8'h00;
   logic [7:0] rd_data;

   int checks = 0;
   int errors = 0;
   logic m_tgl = 1'b0;
   logic fired = 1'b0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   poll_status_read u0 (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .busy(busy), .erase(erase),
      .last_byte(last_byte), .array_data(array_data), .rd_data(rd_data)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   // Driver: computes the expected word from the requirements, queues it, pulses the strobe.
   task automatic do_read(input logic b, input logic e, input logic [7:0] lb,
                          input logic [7:0] arr, input string tag);
      logic [7:0] exp;
      if (!b) exp = arr;                                   // R2
      else begin
         exp = arr;                                        // R8 default pass-through
         exp[7] = e ? 1'b0 : ~lb[7];                       // R3 / R4
         exp[6] = m_tgl;                                   // R5
         m_tgl = ~m_tgl;                                   // R6: only busy reads advance
      end
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      busy = b; erase = e; last_byte = lb; array_data = arr;
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         last_byte = last_byte + 8'h3B;
         array_data = array_data ^ 8'hA5;
         @(negedge clk);
      end
   endtask

   // Monitor: pops expected items one cycle after each strobe.
   always @(posedge clk) fired <= rd_stb;
   always @(negedge clk) begin
      if (fired) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: actual %02h expected none", rd_data);
         end else begin
            string t;
            logic [7:0] e;
            t = tag_q.pop_front();
            e = exp_q.pop_front();
            check(t, rd_data, e);
         end
      end
   end

   initial begin
      logic [7:0] held;
      repeat (3) @(negedge clk);
      check("R1 reset rd_data", rd_data, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      do_read(1'b0, 1'b0, 8'h00, 8'h5A, "R2 idle read");
      do_read(1'b0, 1'b0, 8'hFF, 8'hC3, "R2 idle read busy-looking data");
      // First busy read after reset: toggle 0 (R1, R5)
      do_read(1'b1, 1'b0, 8'h80, 8'h15, "R5 first busy toggle/R3 poll");
      do_read(1'b1, 1'b0, 8'h00, 8'h2A, "R3 poll inverse of 0/R5 second");
      do_read(1'b1, 1'b0, 8'h7F, 8'hFF, "R3/R8 pass-through");
      idle(4);
      do_read(1'b1, 1'b0, 8'h80, 8'h00, "R6 toggle held across gap");
      do_read(1'b0, 1'b0, 8'h00, 8'h40, "R6 idle read true data");
      do_read(1'b1, 1'b0, 8'h01, 8'h81, "R6 idle read did not advance toggle");
      // Erase cycle
      do_read(1'b1, 1'b1, 8'h00, 8'hFF, "R4 erase poll zero");
      do_read(1'b1, 1'b1, 8'hFF, 8'h3C, "R4 erase ignores last byte");
      do_read(1'b0, 1'b0, 8'hFF, 8'hFF, "R2 erased array after clear");
      // Hold check
      held = rd_data;
      busy = 1'b1;
      idle(5);
      check("R7 hold without strobe", rd_data, held);
      busy = 1'b0;
      // New busy period continues the toggle
      do_read(1'b1, 1'b0, 8'h00, 8'h99, "R6 next busy period continues");
      do_read(1'b1, 1'b0, 8'h80, 8'h66, "R5 alternate");
      @(negedge clk);
      check("R7 hold after last read", rd_data, (8'h66 & 8'h3F) | {1'b0, m_tgl ? 1'b0 : 1'b1, 6'b0});
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #20000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule